// File: doc/BRIEF.md
# USB Host Channel Interrupt Aggregator

This block collects status events for the channels of a USB host controller and combines them into one interrupt line for the core. Each channel has a sticky event register and a per-bit enable ("mask") register. The transaction engine raises one-cycle strobes for each channel. Each strobe sets a bit in that channel's event register. Software clears a bit by writing one to it.

A channel summary register holds one bit per channel. A channel's bit is set when any event bit of that channel is both recorded and enabled. The interrupt output goes high when any summary bit is set. Both the summary and the interrupt are derived from the channel registers. The only way to clear them is to clear the events in the channel registers.

Several low-level causes feed a single bit. The four line-level failure causes all land in the transaction error bit. The halted event is raised by an explicit stop strobe. It is also raised automatically when a transfer completes or a transaction error occurs.

Top module: `hc_irq_agg`

## Requirements
- R1: After reset every event register, enable register, summary bit and the interrupt output are zero.
- R2: Per-channel source strobes set sticky event bits. The event bit positions are: done=0, halted=1, tx-empty=2, ack=3, nak=4, stall=5, xact-error=6, babble=7, overrun=8, toggle-error=9. The source strobe positions are: done=0, stop=1, tx-empty=2, ack=3, nak=4, stall=5, crc=6, timeout=7, stuff=8, eop=9, babble=10, overrun=11, toggle=12. Each bit becomes visible on the clock edge that samples its strobe.
- R3: Any of the crc, timeout, stuff or eop source strobes sets event bit 6.
- R4: Event bit 1 (halted) is set by the stop strobe. It is also set by the done strobe or by any transaction-error cause.
- R5: A write to a channel's event register at byte offset 0x100+0x20*n+0x08 clears the bits written as one and leaves the other bits unchanged. If a strobe sets a bit in the same cycle that a write clears it, the bit stays set.
- R6: The enable register sits at 0x100+0x20*n+0x0C, bits 9:0, with 1 meaning the event is passed on. Events that are not enabled are still recorded in the event register.
- R7: The summary register at 0x010 holds one bit per channel; bit n is set when channel n has an event that is both recorded and enabled. The summary is updated one clock after the event or enable register changes.
- R8: `irq_o` is high exactly when any summary bit is set, with the same one-clock timing as the summary.
- R9: After a clear, the summary bit and `irq_o` drop one clock later, unless other enabled events are still pending.
- R10: A read returns its data on `bus_rdata_o` after the clock edge that samples it. Reads of unmapped addresses return zero. Writes to the summary address or to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_src_i | input | NUM_CH*13 | Per-channel source strobes, channel n at bits [13n+12:13n] |
| bus_en_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Core host-channel interrupt |

## Verification
A lost or spuriously kept event bit shows up in two places. It appears on the very next read of that channel's event register. It also reaches `irq_o` one clock after the event or enable register changes, provided that bit is enabled. A wrong summary bit reaches `irq_o` in the same cycle and the next summary read. A bench model mirrors the event and enable registers, so the interrupt is compared every cycle and every read is compared on the following cycle.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;
  localparam int EVT_W = 10;
  localparam int SRC_W = 13;

  localparam int B_DONE = 0;
  localparam int B_HALT = 1;
  localparam int B_TXE  = 2;
  localparam int B_ACK  = 3;
  localparam int B_NAK  = 4;
  localparam int B_STL  = 5;
  localparam int B_XERR = 6;
  localparam int B_BAB  = 7;
  localparam int B_OVR  = 8;
  localparam int B_TGL  = 9;

  localparam int S_DONE  = 0;
  localparam int S_STOP  = 1;
  localparam int S_TXE   = 2;
  localparam int S_ACK   = 3;
  localparam int S_NAK   = 4;
  localparam int S_STL   = 5;
  localparam int S_CRC   = 6;
  localparam int S_TMO   = 7;
  localparam int S_STUFF = 8;
  localparam int S_EOP   = 9;
  localparam int S_BAB   = 10;
  localparam int S_OVR   = 11;
  localparam int S_TGL   = 12;

  typedef enum logic [1:0] {RD_NONE, RD_STAT, RD_MASK, RD_SUM} rd_kind_e;

  function automatic logic [EVT_W-1:0] map_sources(input logic [SRC_W-1:0] s);
    logic [EVT_W-1:0] e;
    logic             err;
    err       = s[S_CRC] | s[S_TMO] | s[S_STUFF] | s[S_EOP];
    e         = '0;
    e[B_DONE] = s[S_DONE];
    e[B_HALT] = s[S_STOP] | s[S_DONE] | err;
    e[B_TXE]  = s[S_TXE];
    e[B_ACK]  = s[S_ACK];
    e[B_NAK]  = s[S_NAK];
    e[B_STL]  = s[S_STL];
    e[B_XERR] = err;
    e[B_BAB]  = s[S_BAB];
    e[B_OVR]  = s[S_OVR];
    e[B_TGL]  = s[S_TGL];
    return e;
  endfunction
endpackage

// File: rtl/hc_chan_evt.sv
module hc_chan_evt
  import hc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic             st_we_i,
  input  logic             mk_we_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] st_o,
  output logic [EVT_W-1:0] mk_o,
  output logic             pend_o
);
  logic [EVT_W-1:0] src_ev;
  logic [EVT_W-1:0] st_q, st_d, mk_q, mk_d;
  logic             st_en;

  always_comb src_ev = map_sources(src_i);

  // next state: clear first, then set, so a same-cycle set survives
  always_comb begin
    st_d = st_q;
    if (st_we_i) st_d = st_q & ~wdata_i;
    st_d  = st_d | src_ev;
    st_en = st_we_i | (|src_ev);
    mk_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mk_q <= '0;
    else if (mk_we_i) mk_q <= mk_d;
  end

  assign st_o   = st_q;
  assign mk_o   = mk_q;
  assign pend_o = |(st_q & mk_q);

  assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_ev) |=> ((st_q & $past(src_ev)) == $past(src_ev)));

  assert_err_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i[S_CRC] | src_i[S_TMO] | src_i[S_STUFF] | src_i[S_EOP]) |=> (st_q[B_XERR] && st_q[B_HALT]));

  assert_halt_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    src_i[S_DONE] |=> st_q[B_HALT]);

  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we_i && src_i == '0) |=> (st_q == ($past(st_q) & ~$past(wdata_i))));

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mk_we_i |=> $stable(mk_q));
endmodule

// File: rtl/hc_bus_decode.sv
module hc_bus_decode
  import hc_irq_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 12,
  parameter int CH_BASE  = 'h100,
  parameter int SUM_ADDR = 'h010,
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                en_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_CH-1:0]   st_we_o,
  output logic [NUM_CH-1:0]   mk_we_o,
  output rd_kind_e            rd_kind_o,
  output logic [CH_IDX_W-1:0] rd_ch_o
);
  localparam int STRIDE = 32;
  localparam logic [ADDR_W-1:0] CH_LO = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] CH_HI = ADDR_W'(CH_BASE + NUM_CH * STRIDE);
  localparam logic [ADDR_W-1:0] SUM_A = ADDR_W'(SUM_ADDR);

  logic [ADDR_W-1:0]   off;
  logic [CH_IDX_W-1:0] ch;
  logic [4:0]          sub;
  logic                in_ch, is_st, is_mk, is_sum;
  logic                unused_hi;

  always_comb begin
    off    = addr_i - CH_LO;
    ch     = off[CH_IDX_W+4:5];
    sub    = off[4:0];
    in_ch  = (addr_i >= CH_LO) && (addr_i < CH_HI);
    is_st  = in_ch && (sub == 5'h08);
    is_mk  = in_ch && (sub == 5'h0C);
    is_sum = (addr_i == SUM_A);
  end

  assign unused_hi = ^off;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign st_we_o[c] = en_i && wr_i && is_st && (ch == CH_IDX_W'(c));
    assign mk_we_o[c] = en_i && wr_i && is_mk && (ch == CH_IDX_W'(c));
  end

  always_comb begin
    rd_ch_o = ch;
    if (is_st)       rd_kind_o = RD_STAT;
    else if (is_mk)  rd_kind_o = RD_MASK;
    else if (is_sum) rd_kind_o = RD_SUM;
    else             rd_kind_o = RD_NONE;
  end
endmodule

// File: rtl/hc_irq_rollup.sv
module hc_irq_rollup #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] sum_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] sum_q, sum_d;
  logic              irq_q, irq_d;

  always_comb begin
    sum_d = pend_i;
    irq_d = |pend_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sum_q <= sum_d;
      irq_q <= irq_d;
    end
  end

  assign sum_o = sum_q;
  assign irq_o = irq_q;

  assert_irq_when_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_q != '0) |-> irq_q);

  assert_no_irq_without_sum_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (sum_q != '0));

  assert_drop_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> (!irq_q && sum_q == '0));
endmodule

// File: rtl/hc_irq_agg.sv
module hc_irq_agg
  import hc_irq_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CH_BASE  = 'h100,
  parameter int SUM_ADDR = 'h010,
  localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*SRC_W-1:0] evt_src_i,
  input  logic                    bus_en_i,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic                    irq_o
);
  logic [1:0]                   rs_q;
  logic                         rst_int_n;
  logic [NUM_CH-1:0]            st_we, mk_we, pend, sum;
  logic [NUM_CH-1:0][EVT_W-1:0] st_all, mk_all;
  rd_kind_e                     rd_kind;
  logic [CH_IDX_W-1:0]          rd_ch;
  logic [DATA_W-1:0]            rdata_q, rdata_d;
  logic                         rd_en;
  logic                         unused_wdata;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign unused_wdata = ^bus_wdata_i;

  hc_bus_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .SUM_ADDR(SUM_ADDR)
  ) u_dec (
    .en_i(bus_en_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .st_we_o(st_we), .mk_we_o(mk_we), .rd_kind_o(rd_kind), .rd_ch_o(rd_ch)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    hc_chan_evt u_chan (
      .clk(clk), .rst_n(rst_int_n),
      .src_i(evt_src_i[c*SRC_W +: SRC_W]),
      .st_we_i(st_we[c]), .mk_we_i(mk_we[c]),
      .wdata_i(bus_wdata_i[EVT_W-1:0]),
      .st_o(st_all[c]), .mk_o(mk_all[c]), .pend_o(pend[c])
    );
  end

  hc_irq_rollup #(.NUM_CH(NUM_CH)) u_roll (
    .clk(clk), .rst_n(rst_int_n), .pend_i(pend), .sum_o(sum), .irq_o(irq_o)
  );

  always_comb begin
    rd_en = bus_en_i & ~bus_wr_i;
    unique case (rd_kind)
      RD_STAT: rdata_d = DATA_W'(st_all[rd_ch]);
      RD_MASK: rdata_d = DATA_W'(mk_all[rd_ch]);
      RD_SUM:  rdata_d = DATA_W'(sum);
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({st_we, mk_we}));

  assert_no_write_side_effect_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_en_i && bus_wr_i && rd_kind == RD_SUM) |-> (st_we == '0 && mk_we == '0));
endmodule

// File: tb/hc_irq_agg_bench.sv
module hc_irq_agg_bench;
  localparam int NCH = 16;
  localparam int SW  = 13;
  localparam logic [11:0] SUM_A = 12'h010;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH*SW-1:0] evt;
  logic              en, wr;
  logic [11:0]       addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  logic [9:0]     m_st [NCH];
  logic [9:0]     m_mk [NCH];
  logic [NCH-1:0] m_sum;
  logic           m_irq;
  logic [31:0]    m_rd;
  int             last_kind;

  always #5 clk = ~clk;

  hc_irq_agg u_hc_irq_agg (
    .clk(clk), .rst_n(rst_n), .evt_src_i(evt), .bus_en_i(en), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [9:0] ev_map(input logic [12:0] s);
    logic err;
    err = |s[9:6];
    return {s[12], s[11], s[10], err, s[5], s[4], s[3], s[2], s[1] | s[0] | err, s[0]};
  endfunction

  // 0 none, 1 status, 2 enable, 3 summary
  function automatic int kind_of(input logic [11:0] a, output int ch);
    int off;
    ch = 0;
    if (a == SUM_A) return 3;
    if (a < 12'h100 || a >= 12'h300) return 0;
    off = int'(a) - 'h100;
    ch  = off / 32;
    if (off % 32 == 8)  return 1;
    if (off % 32 == 12) return 2;
    return 0;
  endfunction

  function automatic logic [11:0] st_addr(input int c);
    return 12'(32'h108 + 32 * c);
  endfunction
  function automatic logic [11:0] mk_addr(input int c);
    return 12'(32'h10C + 32 * c);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_edge();
    int k, c;
    logic [NCH-1:0] ns;
    k = kind_of(addr, c);
    last_kind = (en && !wr) ? k : -1;
    if (en && !wr) begin
      case (k)
        1: m_rd = {22'd0, m_st[c]};
        2: m_rd = {22'd0, m_mk[c]};
        3: m_rd = {16'd0, m_sum};
        default: m_rd = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) ns[i] = |(m_st[i] & m_mk[i]);
    for (int i = 0; i < NCH; i++) begin
      if (en && wr && k == 1 && c == i) m_st[i] = m_st[i] & ~wdata[9:0];
      m_st[i] = m_st[i] | ev_map(evt[i*SW +: SW]);
      if (en && wr && k == 2 && c == i) m_mk[i] = wdata[9:0];
    end
    m_sum = ns;
    m_irq = |ns;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R8 irq", {31'd0, irq}, {31'd0, m_irq});
    case (last_kind)
      0: check("R10 unmapped read", rdata, m_rd);
      1: check("R2/R5 status read", rdata, m_rd);
      2: check("R6 enable read", rdata, m_rd);
      3: check("R7 summary read", rdata, m_rd);
      default: ;
    endcase
    evt = '0; en = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] v);
    en = 1'b1; wr = 1'b0; addr = a;
    step();
    v = rdata;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    en = 1'b1; wr = 1'b1; addr = a; wdata = d;
    step();
  endtask

  task automatic strobe(input int c, input int s);
    evt[c*SW + s] = 1'b1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    evt = '0; en = 0; wr = 0; addr = '0; wdata = '0;
    for (int i = 0; i < NCH; i++) begin m_st[i] = '0; m_mk[i] = '0; end
    m_sum = '0; m_irq = 0; m_rd = '0; last_kind = -1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 irq in reset", {31'd0, irq}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    do_read(SUM_A, v);      check("R1 summary", v, 32'd0);
    do_read(st_addr(3), v); check("R1 status", v, 32'd0);
    do_read(mk_addr(3), v); check("R1 enable", v, 32'd0);

    // set wins over clear in the same cycle
    strobe(2, 4); step();
    strobe(2, 4); do_write(st_addr(2), 32'h010);
    do_read(st_addr(2), v); check("R5 set wins", v, 32'h010);
    do_write(st_addr(2), 32'h3FF);
    do_read(st_addr(2), v); check("R5 clear", v, 32'h000);

    // each error cause merges into bit 6 plus halted
    for (int s = 6; s <= 9; s++) begin
      strobe(5, s); step();
      do_read(st_addr(5), v); check("R3 error merge", v, 32'h042);
      do_write(st_addr(5), 32'h3FF);
    end
    strobe(4, 0); step();
    do_read(st_addr(4), v); check("R4 done implies halt", v, 32'h003);
    do_write(st_addr(4), 32'h3FF);
    strobe(4, 1); step();
    do_read(st_addr(4), v); check("R4 stop only", v, 32'h002);
    do_write(st_addr(4), 32'h3FF);

    // disabled event recorded, no interrupt
    strobe(7, 3); step(); step();
    check("R6 masked no irq", {31'd0, irq}, 32'd0);
    do_read(st_addr(7), v); check("R6 recorded", v, 32'h008);
    do_write(mk_addr(7), 32'h008);
    step();
    check("R8 irq raised", {31'd0, irq}, 32'd1);
    do_read(SUM_A, v); check("R7 summary bit", v, 32'h0080);

    do_write(mk_addr(1), 32'h001);
    strobe(1, 0); step(); step();
    do_write(st_addr(7), 32'h3FF); step();
    check("R9 other pending", {31'd0, irq}, 32'd1);
    do_read(SUM_A, v); check("R9 summary after clear", v, 32'h0002);
    do_write(st_addr(1), 32'h3FF); step();
    check("R9 irq dropped", {31'd0, irq}, 32'd0);

    // writes to summary / unmapped are ignored
    do_write(SUM_A, 32'hFFFF_FFFF);
    do_write(12'h0F8, 32'hFFFF_FFFF);
    do_write(12'h104, 32'hFFFF_FFFF);
    do_read(SUM_A, v); check("R10 summary unchanged", v, 32'h0);
    do_read(12'h104, v); check("R10 unmapped read", v, 32'h0);
    do_read(mk_addr(0), v); check("R10 enable untouched", v, 32'h0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int op, c;
      for (int b = 0; b < NCH * SW; b++) evt[b] = (($urandom % 100) < 2);
      op = int'($urandom % 8);
      c  = int'($urandom % NCH);
      case (op)
        0, 1: begin en = 1; wr = 0; addr = st_addr(c); end
        2:    begin en = 1; wr = 0; addr = mk_addr(c); end
        3, 4: begin en = 1; wr = 1; addr = st_addr(c); wdata = $urandom; end
        5:    begin en = 1; wr = 1; addr = mk_addr(c); wdata = $urandom; end
        6:    begin en = 1; wr = ($urandom % 2 == 1); addr = SUM_A; wdata = $urandom; end
        default: begin en = ($urandom % 2 == 1); wr = ($urandom % 2 == 1);
                       addr = 12'($urandom % 'h400); wdata = $urandom; end
      endcase
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule